// File: doc/BRIEF.md
# Split Analog/Digital Output Volume Attenuator

This block sits in the playback path ahead of the DAC. It takes a stream of 12-bit two's-complement samples and a 6-bit attenuation code, where each code unit stands for 3 dB. The requested attenuation is split into two parts. Whole 24 dB steps are applied to the samples as arithmetic right shifts. The remaining 0 to 21 dB goes out as a 3-bit step code for an external analog attenuator. Coarse attenuation therefore costs no analog range, and the fine steps never reduce digital resolution.

A mute input replaces the sample with zero. The sample still goes out with its valid strobe, so the downstream driver keeps running and simply produces silence. The attenuation code and the mute input are both sampled only on a cycle that carries a sample. No sample is ever processed with a mix of old and new settings, and the analog step code changes only together with a sample.

Top module: `vol_split_atten`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0, `out_data` is 0 and `ana_step` is 0.
- R2: A sample presented with `in_valid` high appears on `out_data` with `out_valid` high exactly one clock later. `out_valid` is low in any cycle that follows a cycle without `in_valid`.
- R3: Codes 0 to 7 (0 to 21 dB) pass the sample through unchanged and set `ana_step` to the code value.
- R4: Codes 8 to 15 (24 to 45 dB) shift the sample arithmetically right by 4 bits and set `ana_step` to the code minus 8.
- R5: Codes 16 to 23 (48 to 69 dB) shift the sample arithmetically right by 8 bits and set `ana_step` to the code minus 16.
- R6: Codes 24 to 63 are treated as code 23: the sample is shifted right by 8 bits and `ana_step` is 7.
- R7: A sample taken with `mute` high comes out as 0, with `out_valid` still high and `ana_step` still updated from that sample's code.
- R8: A change of `atten_code` or `mute` in cycles without `in_valid` does not affect `out_data` or `ana_step`. Both hold their values until the next sample.
- R9: The shifts extend the sign bit, so negative samples stay negative or become -1 (0xFFF). They never wrap to a positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 12 | Input sample, two's complement |
| atten_code | input | 6 | Attenuation in 3 dB units |
| mute | input | 1 | Force the output sample to zero |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Attenuated sample, two's complement |
| ana_step | output | 3 | Analog attenuator step, 3 dB per unit |

## Verification
The bench targets the code boundaries 7/8, 15/16 and 23/24, as well as code 63. A wrong split there would put 24 dB on the wrong side, or let the analog field wrap to 0 and play loud. The most negative sample and small negative samples are run through both shift depths, so a logical shift shows up as a large positive value. Settings are changed between samples to catch a design that applies them immediately rather than on a sample boundary. A muted sample is checked for a still-asserted strobe and a still-updated analog field.

// File: rtl/vol_atten_pkg.sv
package vol_atten_pkg;

    localparam int SAMPLE_W_D        = 12;
    localparam int CODE_W_D          = 6;
    localparam int ANA_W_D           = 3;
    localparam int DIG_LEVELS_D      = 3;
    localparam int SHIFT_PER_LEVEL_D = 4;

    // Highest meaningful code: every analog step at every digital level.
    function automatic int max_code(input int ana_w, input int dig_levels);
        return dig_levels * (1 << ana_w) - 1;
    endfunction

    // Shift distance applied at a given digital level.
    function automatic int level_shift(input int level, input int per_level);
        return level * per_level;
    endfunction

endpackage

// File: rtl/vol_code_split.sv
module vol_code_split
    import vol_atten_pkg::*;
#(
    parameter int CODE_W     = CODE_W_D,
    parameter int ANA_W      = ANA_W_D,
    parameter int DIG_LEVELS = DIG_LEVELS_D,
    parameter int DIG_W      = $clog2(DIG_LEVELS)
) (
    input  logic [CODE_W-1:0] code,
    output logic [DIG_W-1:0]  dig_level,
    output logic [ANA_W-1:0]  ana_part
);
    localparam int TOP_CODE = max_code(ANA_W, DIG_LEVELS);

    logic [CODE_W-1:0] clamped;

    always_comb begin
        if (code > CODE_W'(TOP_CODE)) clamped = CODE_W'(TOP_CODE);
        else                          clamped = code;
        dig_level = DIG_W'(clamped >> ANA_W);
        ana_part  = ANA_W'(clamped);
    end
endmodule

// File: rtl/vol_shifter.sv
module vol_shifter
    import vol_atten_pkg::*;
#(
    parameter int SAMPLE_W        = SAMPLE_W_D,
    parameter int DIG_LEVELS      = DIG_LEVELS_D,
    parameter int SHIFT_PER_LEVEL = SHIFT_PER_LEVEL_D,
    parameter int DIG_W           = $clog2(DIG_LEVELS)
) (
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic        [DIG_W-1:0]    level,
    output logic signed [SAMPLE_W-1:0] dout
);
    logic signed [SAMPLE_W-1:0] per_level [DIG_LEVELS];

    for (genvar g = 0; g < DIG_LEVELS; g++) begin : g_level
        assign per_level[g] = din >>> level_shift(g, SHIFT_PER_LEVEL);
    end

    always_comb begin
        dout = per_level[0];
        for (int k = 1; k < DIG_LEVELS; k++) begin
            if (level == DIG_W'(k)) dout = per_level[k];
        end
    end
endmodule

// File: rtl/vol_out_stage.sv
module vol_out_stage #(
    parameter int SAMPLE_W = 12,
    parameter int ANA_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic                silence,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [ANA_W-1:0]    ana_next,
    output logic                q_valid,
    output logic [SAMPLE_W-1:0] q_data,
    output logic [ANA_W-1:0]    q_ana
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_ana   <= '0;
        end else begin
            q_valid <= take;
            if (take) begin
                q_data <= silence ? '0 : sample;
                q_ana  <= ana_next;
            end
        end
    end
endmodule

// File: rtl/vol_split_atten.sv
module vol_split_atten
    import vol_atten_pkg::*;
#(
    parameter int SAMPLE_W        = SAMPLE_W_D,
    parameter int CODE_W          = CODE_W_D,
    parameter int ANA_W           = ANA_W_D,
    parameter int DIG_LEVELS      = DIG_LEVELS_D,
    parameter int SHIFT_PER_LEVEL = SHIFT_PER_LEVEL_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic [CODE_W-1:0]   atten_code,
    input  logic                mute,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [ANA_W-1:0]    ana_step
);
    localparam int DIG_W = $clog2(DIG_LEVELS);

    logic [DIG_W-1:0]           dig_level;
    logic [ANA_W-1:0]           ana_part;
    logic signed [SAMPLE_W-1:0] shifted;

    vol_code_split #(
        .CODE_W(CODE_W), .ANA_W(ANA_W), .DIG_LEVELS(DIG_LEVELS), .DIG_W(DIG_W)
    ) u_split (
        .code(atten_code), .dig_level(dig_level), .ana_part(ana_part)
    );

    vol_shifter #(
        .SAMPLE_W(SAMPLE_W), .DIG_LEVELS(DIG_LEVELS),
        .SHIFT_PER_LEVEL(SHIFT_PER_LEVEL), .DIG_W(DIG_W)
    ) u_shift (
        .din($signed(in_data)), .level(dig_level), .dout(shifted)
    );

    vol_out_stage #(.SAMPLE_W(SAMPLE_W), .ANA_W(ANA_W)) u_out (
        .clk(clk), .rst(rst), .take(in_valid), .silence(mute),
        .sample(shifted), .ana_next(ana_part),
        .q_valid(out_valid), .q_data(out_data), .q_ana(ana_step)
    );
endmodule

// File: rtl/vol_split_atten_chk.sv
module vol_split_atten_chk #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 6,
    parameter int ANA_W    = 3,
    parameter int TOP_CODE = 23
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_data,
    input logic [CODE_W-1:0]   atten_code,
    input logic                mute,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_data,
    input logic [ANA_W-1:0]    ana_step
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_mute_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mute) |=> (out_valid && out_data == '0));

    assert_hold_between_samples_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(ana_step)));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && atten_code > CODE_W'(TOP_CODE)) |=> ana_step == '1);

    assert_sign_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mute && in_data[SAMPLE_W-1]) |=> out_data[SAMPLE_W-1]);

    assert_no_wrap_positive_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_data[SAMPLE_W-1]) |=> !out_data[SAMPLE_W-1]);
endmodule

bind vol_split_atten vol_split_atten_chk #(
    .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .ANA_W(ANA_W),
    .TOP_CODE(DIG_LEVELS * (1 << ANA_W) - 1)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .atten_code(atten_code), .mute(mute), .out_valid(out_valid),
    .out_data(out_data), .ana_step(ana_step)
);

// File: tb/vol_split_atten_tb.sv
`timescale 1ns/1ps
module vol_split_atten_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [11:0] in_data;
    logic [5:0]  atten_code;
    logic        mute;
    logic        out_valid;
    logic [11:0] out_data;
    logic [2:0]  ana_step;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vol_split_atten u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .atten_code(atten_code), .mute(mute), .out_valid(out_valid),
        .out_data(out_data), .ana_step(ana_step)
    );

    typedef struct packed {
        logic [11:0] din;
        logic [5:0]  code;
        logic        mt;
        logic [11:0] exp_d;
        logic [2:0]  exp_a;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{12'h123,  6'd0, 1'b0, 12'h123, 3'd0},  // R3
        '{12'h800,  6'd7, 1'b0, 12'h800, 3'd7},  // R3
        '{12'h7FF,  6'd8, 1'b0, 12'h07F, 3'd0},  // R4
        '{12'h800,  6'd9, 1'b0, 12'hF80, 3'd1},  // R4 R9
        '{12'hFFF, 6'd15, 1'b0, 12'hFFF, 3'd7},  // R4 R9
        '{12'h010, 6'd12, 1'b0, 12'h001, 3'd4},  // R4
        '{12'h7FF, 6'd16, 1'b0, 12'h007, 3'd0},  // R5
        '{12'h800, 6'd23, 1'b0, 12'hFF8, 3'd7},  // R5 R9
        '{12'h0FF, 6'd18, 1'b0, 12'h000, 3'd2},  // R5
        '{12'hF00, 6'd20, 1'b0, 12'hFFF, 3'd4},  // R5 R9
        '{12'h400, 6'd24, 1'b0, 12'h004, 3'd7},  // R6
        '{12'h7FF, 6'd63, 1'b0, 12'h007, 3'd7},  // R6
        '{12'h555,  6'd5, 1'b1, 12'h000, 3'd5},  // R7
        '{12'h800, 6'd12, 1'b1, 12'h000, 3'd4}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] d, input logic [5:0] c, input logic m);
        in_valid   = 1'b1;
        in_data    = d;
        atten_code = c;
        mute       = m;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; atten_code = '0; mute = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 0);
        check("R1 data in reset", 32'(out_data), 0);
        check("R1 ana in reset", 32'(ana_step), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 0);
        check("R1 ana after reset", 32'(ana_step), 0);

        // table walk, each sample then an idle cycle
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].din, VECS[i].code, VECS[i].mt);
            @(negedge clk);
            in_valid = 1'b0;
            check("R2 valid one cycle later", 32'(out_valid), 1);
            check("R3-R7 data", 32'(out_data), 32'(VECS[i].exp_d));
            check("R3-R7 ana", 32'(ana_step), 32'(VECS[i].exp_a));
            @(negedge clk);
            check("R2 valid drops", 32'(out_valid), 0);
        end

        // R8: settings change without a sample, outputs hold
        drive(12'h300, 6'd2, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 setup data", 32'(out_data), 32'h300);
        atten_code = 6'd20;
        mute = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 data held", 32'(out_data), 32'h300);
        check("R8 ana held", 32'(ana_step), 2);
        check("R8 valid low", 32'(out_valid), 0);
        drive(12'h300, 6'd20, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 new code on sample data", 32'(out_data), 32'h003);
        check("R8 new code on sample ana", 32'(ana_step), 4);

        // back-to-back samples with different codes
        drive(12'h7F0, 6'd8, 1'b0);
        @(negedge clk);
        drive(12'h7F0, 6'd17, 1'b0);
        check("R4 back-to-back first data", 32'(out_data), 32'h07F);
        check("R4 back-to-back first ana", 32'(ana_step), 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back valid", 32'(out_valid), 1);
        check("R5 back-to-back second data", 32'(out_data), 32'h007);
        check("R5 back-to-back second ana", 32'(ana_step), 1);
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule